// File: doc/BRIEF.md
# Event Interrupt Status Unit

This block collects single-cycle event pulses from a set of sources into sticky status bits and raises one level interrupt while any unmasked status bit is set. Software reaches it through a small register port: a status register that is cleared by writing ones, a mask register, and a mirror register. Writing ones to the mirror sets status bits, so software can force an interrupt. Reading the mirror returns the live status.

An enable input qualifies the hardware events. While it is low, new pulses are not recorded, and status that was already captured is kept. The source count is a parameter. A transmit-side instance uses 3 sources (bits 0 to 2). A receive-side instance uses 9 sources (bits 0 to 8), with bit 0 carrying the frame-done event.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, status, mask and `irq` are all 0, and every register address reads 0.
- R2: A pulse on `evt_pulse[i]` while `path_en` is 1 sets status bit i at that clock edge. Bit i of each register belongs to source i.
- R3: A status bit stays set until software clears it.
- R4: Writing to address 0 (status) clears each status bit whose write-data bit is 1. Data bits that are 0 leave status unchanged.
- R5: Writing to address 2 (mirror) sets each status bit whose write-data bit is 1, whatever the value of `path_en`.
- R6: Reading address 2 returns the same value as reading address 0, including after a clear made through address 0.
- R7: While `path_en` is 0, event pulses are ignored and existing status bits are unchanged.
- R8: Address 1 holds the mask and reads back the bits that were written. A mask bit of 1 keeps its source off `irq`, while the status bit still records the event.
- R9: `irq` is a register. One cycle after any status bit with a mask of 0 is set, `irq` is 1. One cycle after no such bit remains, `irq` is 0.
- R10: When an enabled event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R11: Address 3 reads 0, and writes to it change nothing. Data bits at or above the source count read 0 and are ignored on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_en | input | 1 | Qualifies hardware event capture |
| evt_pulse | input | NSRC | One pulse per source, sampled at each clock edge |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 mirror, 3 spare |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions assume that `path_en` and `evt_pulse` are driven to known values in every cycle after reset. They also assume that only one register write happens per cycle, so a force and a clear can never reach the same bit together. The bench changes inputs only on the falling clock edge and issues one write at a time. It sweeps every source bit through event capture, force, clear, masking and the event-versus-clear collision.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int unsigned SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_STATUS = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_MIRROR = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
   parameter int unsigned NSRC = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            path_en,
   input  logic [NSRC-1:0] evt,
   input  logic [NSRC-1:0] clr,
   input  logic [NSRC-1:0] force_set,
   output logic [NSRC-1:0] st
);
   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      logic hw_set;
      assign hw_set = evt[i] & path_en;

      // The set terms are ORed in after the clear term, so an event or a force beats a clear.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[i] <= 1'b0;
         else        st[i] <= (st[i] & ~clr[i]) | hw_set | force_set[i];
      end

      // R3
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         st[i] && !clr[i] |=> st[i]);
      // R10
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] && path_en |=> st[i]);
      // R7
      gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !path_en && !force_set[i] && !st[i] |=> !st[i]);
      // R5
      force_chk: assert property (@(posedge clk) disable iff (!rst_n)
         force_set[i] |=> st[i]);
   end
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
   parameter int unsigned NSRC = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [NSRC-1:0] wdata,
   output logic [NSRC-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask <= '0;
      else if (wr) mask <= wdata;
   end
endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
   parameter int unsigned NSRC = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] st,
   input  logic [NSRC-1:0] mask,
   output logic            irq
);
   logic [NSRC-1:0] live;
   assign live = st & ~mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |live;
   end

   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(st & ~mask)) |=> irq);
   // R9
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(st & ~mask)) |=> !irq);
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
   import evt_irq_pkg::*;
#(
   parameter int unsigned NSRC = 9,
   parameter int unsigned DW   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             path_en,
   input  logic [NSRC-1:0]  evt_pulse,
   input  logic             reg_wr,
   input  logic [SEL_W-1:0] reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic             irq
);
   if (NSRC < 1 || NSRC > DW) begin : g_bad_cfg
      $error("evt_irq_unit: NSRC must lie between 1 and DW");
   end

   logic [NSRC-1:0] st, mask, clr, force_set, wbits;
   logic            mask_wr;
   reg_sel_e        sel;

   assign sel     = reg_sel_e'(reg_addr);
   assign wbits   = reg_wdata[NSRC-1:0];
   assign clr     = (reg_wr && sel == SEL_STATUS) ? wbits : '0;
   assign force_set = (reg_wr && sel == SEL_MIRROR) ? wbits : '0;
   assign mask_wr = reg_wr && sel == SEL_MASK;

   evt_irq_status #(.NSRC(NSRC)) u_status (
      .clk(clk), .rst_n(rst_n), .path_en(path_en), .evt(evt_pulse),
      .clr(clr), .force_set(force_set), .st(st));

   evt_irq_mask #(.NSRC(NSRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(wbits), .mask(mask));

   evt_irq_combine #(.NSRC(NSRC)) u_combine (
      .clk(clk), .rst_n(rst_n), .st(st), .mask(mask), .irq(irq));

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_STATUS, SEL_MIRROR: reg_rdata[NSRC-1:0] = st;
         SEL_MASK:               reg_rdata[NSRC-1:0] = mask;
         default:                reg_rdata = '0;
      endcase
   end

   // R8
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask));
endmodule

// File: tb/evt_irq_unit_bench.sv
module evt_irq_unit_bench;
   localparam int N  = 9;
   localparam int DW = 16;

   logic          clk = 0, rst_n = 0, path_en = 0, reg_wr = 0;
   logic [N-1:0]  evt_pulse = '0;
   logic [1:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0, reg_rdata;
   logic          irq;
   int            checks = 0, errors = 0;
   bit            done = 0;
   logic [DW-1:0] rv;
   logic [N-1:0]  allb;

   always #10 clk = ~clk;

   evt_irq_unit #(.NSRC(N), .DW(DW)) u_evt_irq_unit (
      .clk(clk), .rst_n(rst_n), .path_en(path_en), .evt_pulse(evt_pulse),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq));

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic pulse(input logic [N-1:0] p);
      evt_pulse = p;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      allb = '1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: every address and irq read 0 after reset
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], rv); check("R1 reset read", rv, '0);
      end
      check("R1 irq", {15'b0, irq}, '0);

      path_en = 1;
      for (int i = 0; i < N; i++) begin
         pulse(N'(1) << i);
         rd(2'd0, rv); check("R2 event sets bit", rv, DW'(1) << i);
         repeat (3) @(negedge clk);
         rd(2'd0, rv); check("R3 sticky", rv, DW'(1) << i);
         rd(2'd2, rv); check("R6 mirror equals status", rv, DW'(1) << i);
         check("R9 irq raised", {15'b0, irq}, 16'd1);
         wr(2'd0, ~(DW'(1) << i));
         rd(2'd0, rv); check("R4 zero bits no effect", rv, DW'(1) << i);
         wr(2'd0, DW'(1) << i);
         rd(2'd2, rv); check("R4 R6 cleared seen at mirror", rv, '0);
         @(negedge clk);
         check("R9 irq dropped", {15'b0, irq}, '0);
      end

      path_en = 0;
      for (int i = 0; i < N; i++) begin
         wr(2'd2, DW'(1) << i);
         rd(2'd0, rv); check("R5 force", rv, DW'((N'(2) << i) - N'(1)));
      end
      wr(2'd0, '1);
      rd(2'd0, rv); check("R4 clear all", rv, '0);

      // R7: disabled path keeps existing bits
      path_en = 1; pulse(9'h005);
      path_en = 0; pulse(allb);
      rd(2'd0, rv); check("R7 events ignored", rv, 16'h0005);
      path_en = 1;
      wr(2'd0, '1);

      // R8: mask readback, masked source still records
      wr(2'd1, 16'hFFFF);
      rd(2'd1, rv); check("R8 R11 mask readback", rv, 16'h01FF);
      pulse(9'h008);
      @(negedge clk);
      rd(2'd0, rv); check("R8 masked still records", rv, 16'h0008);
      check("R8 masked irq low", {15'b0, irq}, '0);
      wr(2'd2, '1);
      for (int i = 0; i < N; i++) begin
         wr(2'd1, DW'(~(N'(1) << i)));
         @(negedge clk);
         check("R8 R9 single unmasked", {15'b0, irq}, 16'd1);
         wr(2'd1, '1);
         @(negedge clk);
         check("R8 all masked", {15'b0, irq}, '0);
      end
      wr(2'd0, '1);
      wr(2'd1, '0);

      // R10: event and clear together, event wins
      for (int i = 0; i < N; i++) begin
         evt_pulse = N'(1) << i;
         wr(2'd0, '1);
         evt_pulse = '0;
         rd(2'd0, rv); check("R10 event beats clear", rv, DW'(1) << i);
         wr(2'd0, '1);
      end

      // R11: spare address
      wr(2'd3, 16'hFFFF);
      rd(2'd3, rv); check("R11 spare reads 0", rv, '0);
      rd(2'd0, rv); check("R11 spare write no status", rv, '0);
      rd(2'd1, rv); check("R11 spare write no mask", rv, '0);
      @(negedge clk);
      check("R11 irq idle", {15'b0, irq}, '0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule